// File: doc/BRIEF.md
# Redundant Reference Clock Selector

This block picks which of two timing references, primary or secondary, feeds a downstream PLL. It drives only a select signal and does not switch any clock net. Software chooses the reference through a small register file. The block can also fail over on its own. In that case the trigger is one of two things, chosen by a mode bit: loss of signal on the reference in use, or the PLL entering holdover.

The reference requested by software and the reference actually in use are read back as separate bits. Software learns that a switchover happened by comparing the in-use bit before and after an event. The two loss-of-signal flags, the PLL holdover flag and the PLL unlock flag come from the timing domain and are synchronized before use. A read-only alarm byte reports these four flags.

The register port is byte wide. Each write carries a per-bit mask, so a field can be updated without disturbing the other bits of the same register.

Top module: `ref_clk_selector`

## Requirements
- R1: After reset, every register reads 0 and `ref_sel_o` is 0, which selects the primary reference. Automatic switching is off.
- R2: With automatic switching off, `ref_sel_o` copies select register (address 1) bit 0, where 0 is primary and 1 is secondary. It updates on the edge of the write. When automatic switching is turned off, `ref_sel_o` returns to the requested value one edge after the control write.
- R3: Control register (address 0) bit 7 enables automatic switching. Bit 6 selects the trigger: 1 means PLL holdover entry, 0 means loss of the active reference. Both bits read back. Bits 5..0 read 0.
- R4: Select register bit 3 reads the reference in use and ignores writes. Bit 0 reads the requested reference. All other bits read 0.
- R5: The alarm register (address 2) reads bit 7 = primary lost, bit 6 = secondary lost, bit 5 = holdover, bit 4 = unlock. Bits 3..0 read 0. Writes to it have no effect.
- R6: In loss trigger mode with switching on, loss of the active reference moves `ref_sel_o` to the other reference when that reference is not lost. The change appears on the third clock edge after the input change. There is no automatic return when the lost reference recovers.
- R7: In holdover trigger mode, only a rising edge of holdover causes a switch, and only one switch per edge. Loss of the active reference alone does not switch.
- R8: When both references are lost, no automatic switch happens. When the other reference recovers while the active one is still lost, the switch takes place.
- R9: A write that touches select bit 0 while automatic switching is on forces `ref_sel_o` to the written value on that edge.
- R10: A write changes only the bits whose `wmask_i` bit is 1.
- R11: Status inputs pass through two synchronizer flops. The alarm register shows a change after the second clock edge, not after the first.
- R12: Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| wmask_i | input | 8 | Per-bit write enable |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pri_los_i | input | 1 | Primary loss of signal, asynchronous |
| sec_los_i | input | 1 | Secondary loss of signal, asynchronous |
| holdover_i | input | 1 | PLL in holdover, asynchronous |
| unlock_i | input | 1 | PLL unlocked, asynchronous |
| ref_sel_o | output | 1 | Reference in use: 0 primary, 1 secondary |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Both references lost.** A selector that ignores the state of the other reference would switch onto a dead clock.
- **Holdover held high.** A level-triggered selector would switch back and forth every cycle.
- **Forced write onto a lost reference.** The override must take effect on the write edge, and the automatic logic must then move the select away again one cycle later.
- **Synchronizer depth.** Reading the alarm byte after one edge and then after two exposes a missing or extra flop. The failover timing is counted the same way.
- **Masked writes.** Writes whose mask excludes a field show whether the design corrupts neighbouring bits.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  localparam int unsigned DATA_W = 8;

  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_SEL   = 1;
  localparam int unsigned ADDR_ALARM = 2;

  localparam int unsigned CTRL_AUTO_BIT = 7;
  localparam int unsigned CTRL_TRIG_BIT = 6;
  localparam int unsigned SEL_REQ_BIT   = 0;
  localparam int unsigned SEL_ACT_BIT   = 3;

  localparam logic [DATA_W-1:0] CTRL_IMPL = 8'hC0;
  localparam logic [DATA_W-1:0] SEL_IMPL  = 8'h01;

  // field order matches alarm bits 7..4
  typedef struct packed {
    logic pri_los;
    logic sec_los;
    logic holdover;
    logic unlock;
  } tstat_t;

  localparam int unsigned TSTAT_W = $bits(tstat_t);

  function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [DATA_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/ref_sel_sync.sv
module ref_sel_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ref_sel_regs.sv
module ref_sel_regs
  import ref_sel_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic              active_i,
  input  tstat_t            status_i,
  output logic              auto_en_o,
  output logic              trig_hold_o,
  output logic              req_sel_o,
  output logic              sel_wr_o,
  output logic              sel_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] ctrl_q, sel_q;
  logic hit_ctrl, hit_sel, hit_alarm;

  assign hit_ctrl  = addr_i == ADDR_W'(ADDR_CTRL);
  assign hit_sel   = addr_i == ADDR_W'(ADDR_SEL);
  assign hit_alarm = addr_i == ADDR_W'(ADDR_ALARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (we_i) begin
      if (hit_ctrl) ctrl_q <= merge_bits(ctrl_q, wdata_i, wmask_i) & CTRL_IMPL;
      if (hit_sel)  sel_q  <= merge_bits(sel_q, wdata_i, wmask_i) & SEL_IMPL;
    end
  end

  assign auto_en_o   = ctrl_q[CTRL_AUTO_BIT];
  assign trig_hold_o = ctrl_q[CTRL_TRIG_BIT];
  assign req_sel_o   = sel_q[SEL_REQ_BIT];
  assign sel_wr_o    = we_i && hit_sel && wmask_i[SEL_REQ_BIT];
  assign sel_wdata_o = wdata_i[SEL_REQ_BIT];

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o = ctrl_q;
    end else if (hit_sel) begin
      rdata_o = sel_q;
      rdata_o[SEL_ACT_BIT] = active_i;
    end else if (hit_alarm) begin
      rdata_o[DATA_W-1 -: TSTAT_W] = status_i;
    end
  end
endmodule

// File: rtl/ref_sel_failover.sv
module ref_sel_failover
  import ref_sel_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   auto_en_i,
  input  logic   trig_hold_i,
  input  logic   req_sel_i,
  input  logic   sel_wr_i,
  input  logic   sel_wdata_i,
  input  tstat_t status_i,
  output logic   active_o
);
  logic active_q, active_d, hold_prev_q;
  logic hold_rise, cur_los, alt_los, trigger;

  assign hold_rise = status_i.holdover && !hold_prev_q;
  assign cur_los   = active_q ? status_i.sec_los : status_i.pri_los;
  assign alt_los   = active_q ? status_i.pri_los : status_i.sec_los;
  assign trigger   = trig_hold_i ? hold_rise : cur_los;

  always_comb begin
    active_d = active_q;
    if (sel_wr_i)                active_d = sel_wdata_i;
    else if (!auto_en_i)         active_d = req_sel_i;
    else if (trigger && !alt_los) active_d = !active_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      hold_prev_q <= 1'b0;
    end else begin
      active_q    <= active_d;
      hold_prev_q <= status_i.holdover;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
  import ref_sel_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        wmask_i,
  output logic [7:0]        rdata_o,
  input  logic              pri_los_i,
  input  logic              sec_los_i,
  input  logic              holdover_i,
  input  logic              unlock_i,
  output logic              ref_sel_o
);
  logic [TSTAT_W-1:0] status_raw, status_bits;
  tstat_t status_s;
  logic auto_en, trig_hold, req_sel, sel_wr, sel_wdata, active;

  assign status_raw = {pri_los_i, sec_los_i, holdover_i, unlock_i};

  ref_sel_sync #(.WIDTH(TSTAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (status_raw),
    .q_o   (status_bits)
  );
  assign status_s = tstat_t'(status_bits);

  ref_sel_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wmask_i    (wmask_i),
    .active_i   (active),
    .status_i   (status_s),
    .auto_en_o  (auto_en),
    .trig_hold_o(trig_hold),
    .req_sel_o  (req_sel),
    .sel_wr_o   (sel_wr),
    .sel_wdata_o(sel_wdata),
    .rdata_o    (rdata_o)
  );

  ref_sel_failover u_fail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_en_i  (auto_en),
    .trig_hold_i(trig_hold),
    .req_sel_i  (req_sel),
    .sel_wr_i   (sel_wr),
    .sel_wdata_i(sel_wdata),
    .status_i   (status_s),
    .active_o   (active)
  );

  assign ref_sel_o = active;
endmodule

// File: rtl/ref_clk_selector_checker.sv
module ref_clk_selector_checker #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        wmask_i,
  input logic [7:0]        rdata_o,
  input logic              ref_sel_o,
  input logic              auto_en,
  input logic              req_sel,
  input logic [3:0]        status_bits
);
  logic sel_touch;
  assign sel_touch = we_i && addr_i == ADDR_W'(1) && wmask_i[0];

  a_r9_write_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_touch |=> ref_sel_o == $past(wdata_i[0]));

  a_r2_manual_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en && !sel_touch) |=> ref_sel_o == $past(req_sel));

  a_r8_both_lost_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en && status_bits[3] && status_bits[2] && !sel_touch) |=> $stable(ref_sel_o));

  a_r5_alarm_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(2)) |-> rdata_o == {status_bits, 4'b0000});

  a_r4_active_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(1)) |-> (rdata_o[3] == ref_sel_o && rdata_o[7:4] == 4'b0000));

  a_r12_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(3)) |-> rdata_o == 8'h00);
endmodule

bind ref_clk_selector ref_clk_selector_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wmask_i    (wmask_i),
  .rdata_o    (rdata_o),
  .ref_sel_o  (ref_sel_o),
  .auto_en    (auto_en),
  .req_sel    (req_sel),
  .status_bits(status_bits)
);

// File: tb/ref_clk_selector_bench.sv
module ref_clk_selector_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, wmask_i = '0, rdata_o;
  logic pri_los_i = 1'b0, sec_los_i = 1'b0, holdover_i = 1'b0, unlock_i = 1'b0;
  logic ref_sel_o;
  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  ref_clk_selector u_ref_clk_selector (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wmask_i(wmask_i), .rdata_o(rdata_o),
    .pri_los_i(pri_los_i), .sec_los_i(sec_los_i), .holdover_i(holdover_i),
    .unlock_i(unlock_i), .ref_sel_o(ref_sel_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m);
    we_i = 1'b1; addr_i = a; wdata_i = d; wmask_i = m;
    @(posedge clk);
    @(negedge clk);
    we_i = 1'b0; wmask_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 sel", v, 8'h00);
    rd(2'd2, v); chk("R1 alarm", v, 8'h00);
    chk("R1 ref_sel", {7'd0, ref_sel_o}, 8'h00);
  endtask

  task automatic t_manual();
    logic [7:0] v;
    wr(2'd1, 8'h01, 8'h01);
    chk("R2 select secondary", {7'd0, ref_sel_o}, 8'h01);
    rd(2'd1, v); chk("R4 sel readback", v, 8'h09);
    wr(2'd1, 8'h08, 8'hFF);
    rd(2'd1, v); chk("R4 bit3 write ignored", v, 8'h00);
    chk("R2 select primary", {7'd0, ref_sel_o}, 8'h00);
  endtask

  task automatic t_ctrl_mask();
    logic [7:0] v;
    wr(2'd0, 8'hFF, 8'h40);
    rd(2'd0, v); chk("R10 only bit6", v, 8'h40);
    wr(2'd0, 8'h00, 8'h80);
    rd(2'd0, v); chk("R10 bit6 kept", v, 8'h40);
    wr(2'd0, 8'h80, 8'h80);
    rd(2'd0, v); chk("R3 both bits", v, 8'hC0);
    wr(2'd0, 8'h3F, 8'h3F);
    rd(2'd0, v); chk("R3 low bits read 0", v, 8'hC0);
    wr(2'd0, 8'h00, 8'hFF);
    wr(2'd1, 8'h01, 8'h00);
    rd(2'd1, v); chk("R10 empty mask", v, 8'h00);
    chk("R10 ref_sel unchanged", {7'd0, ref_sel_o}, 8'h00);
  endtask

  task automatic t_alarm_sync();
    logic [7:0] v;
    pri_los_i = 1'b1;
    step(1); rd(2'd2, v); chk("R11 one edge", v, 8'h00);
    step(1); rd(2'd2, v); chk("R11 two edges", v, 8'h80);
    sec_los_i = 1'b1; holdover_i = 1'b1; unlock_i = 1'b1;
    step(2); rd(2'd2, v); chk("R5 all alarms", v, 8'hF0);
    wr(2'd2, 8'h00, 8'hFF);
    rd(2'd2, v); chk("R5 write ignored", v, 8'hF0);
    pri_los_i = 1'b0; sec_los_i = 1'b0; holdover_i = 1'b0;
    step(2); rd(2'd2, v); chk("R5 unlock only", v, 8'h10);
    unlock_i = 1'b0;
    step(2);
  endtask

  task automatic t_los_mode();
    logic [7:0] v;
    wr(2'd0, 8'h80, 8'hC0);
    pri_los_i = 1'b1;
    step(2); chk("R6 not before third edge", {7'd0, ref_sel_o}, 8'h00);
    step(1); chk("R6 switched", {7'd0, ref_sel_o}, 8'h01);
    rd(2'd1, v); chk("R4 active differs from request", v, 8'h08);
    pri_los_i = 1'b0;
    step(4); chk("R6 no switch back", {7'd0, ref_sel_o}, 8'h01);
    wr(2'd0, 8'h00, 8'h80);
    step(1); chk("R2 auto off reverts", {7'd0, ref_sel_o}, 8'h00);
  endtask

  task automatic t_holdover_mode();
    wr(2'd0, 8'hC0, 8'hC0);
    pri_los_i = 1'b1;
    step(4); chk("R7 loss ignored", {7'd0, ref_sel_o}, 8'h00);
    pri_los_i = 1'b0;
    step(3);
    holdover_i = 1'b1;
    step(2); chk("R7 not yet", {7'd0, ref_sel_o}, 8'h00);
    step(1); chk("R7 switched", {7'd0, ref_sel_o}, 8'h01);
    step(5); chk("R7 level no toggle", {7'd0, ref_sel_o}, 8'h01);
    holdover_i = 1'b0;
    step(3);
    holdover_i = 1'b1;
    step(3); chk("R7 second edge", {7'd0, ref_sel_o}, 8'h00);
    holdover_i = 1'b0;
    step(3);
    wr(2'd0, 8'h00, 8'hFF);
    step(1);
  endtask

  task automatic t_both_lost();
    wr(2'd0, 8'h80, 8'hFF);
    sec_los_i = 1'b1;
    step(3);
    pri_los_i = 1'b1;
    step(5); chk("R8 both lost hold", {7'd0, ref_sel_o}, 8'h00);
    sec_los_i = 1'b0;
    step(3); chk("R8 switch on recovery", {7'd0, ref_sel_o}, 8'h01);
    pri_los_i = 1'b0;
    step(3);
  endtask

  task automatic t_force();
    wr(2'd1, 8'h00, 8'h01);
    chk("R9 forced primary", {7'd0, ref_sel_o}, 8'h00);
    wr(2'd1, 8'h01, 8'h01);
    chk("R9 forced secondary", {7'd0, ref_sel_o}, 8'h01);
    pri_los_i = 1'b1;
    step(3);
    wr(2'd1, 8'h00, 8'h01);
    chk("R9 force onto lost ref", {7'd0, ref_sel_o}, 8'h00);
    step(1); chk("R9 auto moves away", {7'd0, ref_sel_o}, 8'h01);
    pri_los_i = 1'b0;
    wr(2'd0, 8'h00, 8'hFF);
    step(3);
  endtask

  task automatic t_spare();
    logic [7:0] v;
    wr(2'd3, 8'hFF, 8'hFF);
    rd(2'd3, v); chk("R12 spare reads 0", v, 8'h00);
    rd(2'd0, v); chk("R12 ctrl untouched", v, 8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    t_reset();
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_manual();
    t_ctrl_mask();
    t_alarm_sync();
    t_los_mode();
    t_holdover_mode();
    t_both_lost();
    t_force();
    t_spare();
    finish_run();
  end
endmodule